// File: doc/BRIEF.md
# Flash Command Guard and Error Flags

This block stands next to the command register that drives a flash array during self-programming. Each time software loads a command code, the block decodes it as an erase, a write or a verify and screens it before the array acts. Erase and write requests aimed at a protected region are stopped. Write requests that would need to turn a 0 bit back into a 1 without an erase first are also stopped. A command that is allowed to run produces a one-cycle strobe toward the array. A command that is stopped produces a one-cycle abort instead.

Two sticky error flags record what went wrong. The protect flag records blocked commands. The verify flag records blocked commands and also failed erase-verify or write-verify results reported back by the array. Software clears a flag by writing 0 to its bit. Reset clears both flags. A later command that succeeds leaves both flags unchanged.

The protected region is every block whose upper address is strictly below a programmable boundary. A boundary of 0 therefore protects nothing.

Top module: `flash_cmd_checker`

## Requirements
- R1: After reset the command register reads 8'h00, both flags read 0, and the erase, write, verify and abort outputs are all 0.
- R2: A write to the command register (cmd_we high) loads cmd_wdata, and cmd_q shows the new value one clock later.
- R3: Erase code 8'h01 with addr_hi greater than or equal to prot_bound pulses erase_stb for exactly one cycle, one clock after the command write. It sets no flag.
- R4: Erase (8'h01) or write (8'h02) with addr_hi strictly below prot_bound pulses abort one clock later and gives no erase or write strobe. The same edge sets the protect flag and the verify flag.
- R5: Write code 8'h02 in an unprotected region, where any byte of wr_data has a 1 in a bit position in which the same byte of rd_data has a 0, gives an abort. It sets both flags the same way as R4.
- R6: Write code 8'h02 in an unprotected region, where every 1 bit of wr_data is already 1 in rd_data, pulses write_stb for one cycle, one clock later.
- R7: Verify code 8'h03 always pulses verify_stb one clock later and is never aborted, even inside the protected region.
- R8: A result report (res_valid high) with res_erase_fail or res_write_fail high sets the verify flag one clock later. It leaves the protect flag unchanged.
- R9: Flags are sticky: once set, a flag stays set through any later commands and results until it is cleared.
- R10: A flag write (flag_we) clears the verify flag when flag_wdata bit 0 is 0 and clears the protect flag when bit 1 is 0. A 1 in a bit leaves that flag as it is. A set condition in the same cycle wins over a clear.
- R11: Any command code other than 8'h01, 8'h02 or 8'h03 still loads cmd_q. It produces no strobe, no abort and no flag change.
- R12: At most one of erase_stb, write_stb, verify_stb and abort is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command register write strobe, which starts a command |
| cmd_wdata | input | 8 | Command code written |
| addr_hi | input | AHW (4) | Upper bits of the target address pointer |
| prot_bound | input | AHW (4) | Protection boundary; blocks below it are protected |
| rd_data | input | 8*NBYTES (16) | Data currently stored at the target |
| wr_data | input | 8*NBYTES (16) | Data to be written |
| res_valid | input | 1 | Array verify result is valid this cycle |
| res_erase_fail | input | 1 | Erase verification failed |
| res_write_fail | input | 1 | Internal write verification failed |
| flag_we | input | 1 | Flag register write strobe |
| flag_wdata | input | 2 | Bit 0 verify flag, bit 1 protect flag; 0 clears |
| cmd_q | output | 8 | Command register contents |
| erase_stb | output | 1 | Erase may proceed |
| write_stb | output | 1 | Write may proceed |
| verify_stb | output | 1 | Verify may proceed |
| abort | output | 1 | Command was blocked |
| verify_err | output | 1 | Sticky verify error flag |
| protect_err | output | 1 | Sticky protect error flag |

## Verification
The assertions assume that addr_hi, prot_bound, rd_data and wr_data hold steady during the cycle in which cmd_we is high. They also assume that the result flags matter only while res_valid is high. The stimulus changes all inputs together once per cycle, on the falling edge, so each command sees one consistent set of operands. Random cycles mix command writes, result reports and flag writes in the same cycle, so that set-versus-clear ordering is exercised. Directed cases cover addr_hi equal to the boundary, a boundary of 0, and a non-blank bit in only the upper byte.

// File: rtl/flcc_pkg.sv
package flcc_pkg;

    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_ERASE  = 2'd1,
        OP_WRITE  = 2'd2,
        OP_VERIFY = 2'd3
    } flash_op_e;

    localparam int unsigned CODE_W = 8;
    localparam logic [CODE_W-1:0] CODE_ERASE  = 8'h01;
    localparam logic [CODE_W-1:0] CODE_WRITE  = 8'h02;
    localparam logic [CODE_W-1:0] CODE_VERIFY = 8'h03;

    localparam int unsigned FLAG_W        = 2;
    localparam int unsigned FLAG_VERR_BIT = 0;
    localparam int unsigned FLAG_PERR_BIT = 1;

    typedef struct packed {
        logic erase;
        logic write;
        logic verify;
        logic abort;
    } action_t;

    typedef struct packed {
        logic range_hit;
        logic not_blank;
    } guard_t;

    function automatic flash_op_e decode_code(input logic [CODE_W-1:0] code);
        flash_op_e op;
        case (code)
            CODE_ERASE:  op = OP_ERASE;
            CODE_WRITE:  op = OP_WRITE;
            CODE_VERIFY: op = OP_VERIFY;
            default:     op = OP_NONE;
        endcase
        return op;
    endfunction

    function automatic action_t resolve(input flash_op_e op, input guard_t g);
        action_t a;
        a = '0;
        case (op)
            OP_ERASE: begin
                if (g.range_hit) a.abort = 1'b1;
                else             a.erase = 1'b1;
            end
            OP_WRITE: begin
                if (g.range_hit || g.not_blank) a.abort = 1'b1;
                else                            a.write = 1'b1;
            end
            OP_VERIFY: a.verify = 1'b1;
            default:   a = '0;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/flcc_region_chk.sv
module flcc_region_chk #(
    parameter int unsigned AHW = 4
) (
    input  logic [AHW-1:0] addr_hi,
    input  logic [AHW-1:0] prot_bound,
    output logic           in_protected
);
    always_comb begin
        in_protected = (addr_hi < prot_bound);
    end
endmodule

// File: rtl/flcc_blank_chk.sv
module flcc_blank_chk #(
    parameter int unsigned NBYTES = 2
) (
    input  logic [8*NBYTES-1:0] rd_data,
    input  logic [8*NBYTES-1:0] wr_data,
    output logic [NBYTES-1:0]   byte_dirty,
    output logic                any_dirty
);
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        logic [7:0] rd_b;
        logic [7:0] wr_b;
        always_comb begin
            rd_b          = rd_data[8*b +: 8];
            wr_b          = wr_data[8*b +: 8];
            byte_dirty[b] = |(wr_b & ~rd_b);
        end
    end

    always_comb begin
        any_dirty = |byte_dirty;
    end
endmodule

// File: rtl/flcc_flag_bank.sv
module flcc_flag_bank
    import flcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              set_perr,
    input  logic              set_verr,
    input  logic              flag_we,
    input  logic [FLAG_W-1:0] flag_wdata,
    output logic              verify_err,
    output logic              protect_err
);
    logic clr_v;
    logic clr_p;
    logic verr_d;
    logic perr_d;

    always_comb begin
        clr_v  = flag_we && !flag_wdata[FLAG_VERR_BIT];
        clr_p  = flag_we && !flag_wdata[FLAG_PERR_BIT];
        verr_d = set_verr || (verify_err && !clr_v);
        perr_d = set_perr || (protect_err && !clr_p);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            verify_err  <= 1'b0;
            protect_err <= 1'b0;
        end else begin
            verify_err  <= verr_d;
            protect_err <= perr_d;
        end
    end

    AST_VERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        verify_err && !clr_v |=> verify_err); // R9
    AST_PERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        protect_err && !clr_p |=> protect_err); // R9
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        set_perr |=> protect_err && verify_err); // R10
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (rst)
        clr_p && !set_perr |=> !protect_err); // R10
endmodule

// File: rtl/flash_cmd_checker.sv
module flash_cmd_checker
    import flcc_pkg::*;
#(
    parameter int unsigned AHW    = 4,
    parameter int unsigned NBYTES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_we,
    input  logic [7:0]          cmd_wdata,
    input  logic [AHW-1:0]      addr_hi,
    input  logic [AHW-1:0]      prot_bound,
    input  logic [8*NBYTES-1:0] rd_data,
    input  logic [8*NBYTES-1:0] wr_data,
    input  logic                res_valid,
    input  logic                res_erase_fail,
    input  logic                res_write_fail,
    input  logic                flag_we,
    input  logic [1:0]          flag_wdata,
    output logic [7:0]          cmd_q,
    output logic                erase_stb,
    output logic                write_stb,
    output logic                verify_stb,
    output logic                abort,
    output logic                verify_err,
    output logic                protect_err
);
    localparam int unsigned DW = 8 * NBYTES;

    flash_op_e         op;
    guard_t            guard;
    action_t           act_d;
    action_t           act_q;
    logic              in_prot;
    logic [NBYTES-1:0] byte_dirty;
    logic              any_dirty;
    logic              res_fail;
    logic              set_perr;
    logic              set_verr;

    flcc_region_chk #(.AHW(AHW)) u_region (
        .addr_hi      (addr_hi),
        .prot_bound   (prot_bound),
        .in_protected (in_prot)
    );

    flcc_blank_chk #(.NBYTES(NBYTES)) u_blank (
        .rd_data    (rd_data[DW-1:0]),
        .wr_data    (wr_data[DW-1:0]),
        .byte_dirty (byte_dirty),
        .any_dirty  (any_dirty)
    );

    always_comb begin
        op              = decode_code(cmd_wdata);
        guard.range_hit = in_prot;
        guard.not_blank = any_dirty;
        act_d           = cmd_we ? resolve(op, guard) : '0;
        res_fail        = res_valid && (res_erase_fail || res_write_fail);
        set_perr        = act_d.abort;
        set_verr        = act_d.abort || res_fail;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= 8'h00;
            act_q <= '0;
        end else begin
            if (cmd_we) cmd_q <= cmd_wdata;
            act_q <= act_d;
        end
    end

    always_comb begin
        erase_stb  = act_q.erase;
        write_stb  = act_q.write;
        verify_stb = act_q.verify;
        abort      = act_q.abort;
    end

    flcc_flag_bank u_flags (
        .clk         (clk),
        .rst         (rst),
        .set_perr    (set_perr),
        .set_verr    (set_verr),
        .flag_we     (flag_we),
        .flag_wdata  (flag_wdata),
        .verify_err  (verify_err),
        .protect_err (protect_err)
    );

    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (rst)
        $onehot0({erase_stb, write_stb, verify_stb, abort})); // R12
    AST_CMDQ_LOAD: assert property (@(posedge clk) disable iff (rst)
        cmd_we |=> cmd_q == $past(cmd_wdata)); // R2
    AST_ABORT_FLAGS: assert property (@(posedge clk) disable iff (rst)
        abort |-> protect_err && verify_err); // R4
    AST_PROT_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        cmd_we && (cmd_wdata == CODE_ERASE || cmd_wdata == CODE_WRITE) && (addr_hi < prot_bound)
        |=> abort && !erase_stb && !write_stb); // R4
    AST_DIRTY_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        cmd_we && cmd_wdata == CODE_WRITE && ((wr_data & ~rd_data) != '0)
        |=> abort && !write_stb); // R5
    AST_VERIFY_PASSES: assert property (@(posedge clk) disable iff (rst)
        cmd_we && cmd_wdata == CODE_VERIFY |=> verify_stb && !abort); // R7
    AST_RES_VERR: assert property (@(posedge clk) disable iff (rst)
        res_valid && (res_erase_fail || res_write_fail) |=> verify_err); // R8
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !cmd_we |=> !erase_stb && !write_stb && !verify_stb && !abort); // R11
endmodule

// File: tb/flash_cmd_checker_tb.sv
module flash_cmd_checker_tb_top;
    localparam int AHW    = 4;
    localparam int NBYTES = 2;
    localparam int DW     = 8 * NBYTES;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           cmd_we = 1'b0;
    logic [7:0]     cmd_wdata = '0;
    logic [AHW-1:0] addr_hi = '0;
    logic [AHW-1:0] prot_bound = '0;
    logic [DW-1:0]  rd_data = '0;
    logic [DW-1:0]  wr_data = '0;
    logic           res_valid = 1'b0;
    logic           res_erase_fail = 1'b0;
    logic           res_write_fail = 1'b0;
    logic           flag_we = 1'b0;
    logic [1:0]     flag_wdata = '0;
    logic [7:0]     cmd_q;
    logic           erase_stb, write_stb, verify_stb, abort;
    logic           verify_err, protect_err;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;

    logic [7:0] exp_cmd = 8'h00;
    logic       exp_v   = 1'b0;
    logic       exp_p   = 1'b0;

    always #10 clk = ~clk;

    flash_cmd_checker #(.AHW(AHW), .NBYTES(NBYTES)) dut_i (
        .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .addr_hi(addr_hi), .prot_bound(prot_bound), .rd_data(rd_data),
        .wr_data(wr_data), .res_valid(res_valid), .res_erase_fail(res_erase_fail),
        .res_write_fail(res_write_fail), .flag_we(flag_we), .flag_wdata(flag_wdata),
        .cmd_q(cmd_q), .erase_stb(erase_stb), .write_stb(write_stb),
        .verify_stb(verify_stb), .abort(abort), .verify_err(verify_err),
        .protect_err(protect_err)
    );

    task automatic check(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Expected action vector {erase, write, verify, abort}
    function automatic logic [3:0] model_action(input logic we, input logic [7:0] code,
            input logic [AHW-1:0] a, input logic [AHW-1:0] b,
            input logic [DW-1:0] rd, input logic [DW-1:0] wr);
        logic prot;
        logic dirty;
        prot = (a < b);
        dirty = ((wr & ~rd) != '0);
        if (!we) return 4'b0000;
        case (code)
            8'h01: return prot ? 4'b0001 : 4'b1000;
            8'h02: return (prot || dirty) ? 4'b0001 : 4'b0100;
            8'h03: return 4'b0010;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic string action_tag(input logic we, input logic [7:0] code,
            input logic [AHW-1:0] a, input logic [AHW-1:0] b,
            input logic [DW-1:0] rd, input logic [DW-1:0] wr);
        if (!we) return "R11";
        case (code)
            8'h01: return (a < b) ? "R4" : "R3";
            8'h02: return (a < b) ? "R4" : (((wr & ~rd) != '0) ? "R5" : "R6");
            8'h03: return "R7";
            default: return "R11";
        endcase
    endfunction

    // Apply one cycle of stimulus at a falling edge, check at the next falling edge.
    task automatic step(input logic we, input logic [7:0] code, input logic [AHW-1:0] a,
            input logic [AHW-1:0] b, input logic [DW-1:0] rd, input logic [DW-1:0] wr,
            input logic rv, input logic ef, input logic wf,
            input logic fwe, input logic [1:0] fwd);
        logic [3:0] exp_act;
        logic       sp, sv;
        string      atag, ftag;
        cmd_we = we; cmd_wdata = code; addr_hi = a; prot_bound = b;
        rd_data = rd; wr_data = wr; res_valid = rv; res_erase_fail = ef;
        res_write_fail = wf; flag_we = fwe; flag_wdata = fwd;
        exp_act = model_action(we, code, a, b, rd, wr);
        atag = action_tag(we, code, a, b, rd, wr);
        sp = exp_act[0];
        sv = exp_act[0] || (rv && (ef || wf));
        if (we) exp_cmd = code;
        exp_p = sp || (exp_p && !(fwe && !fwd[1]));
        exp_v = sv || (exp_v && !(fwe && !fwd[0]));
        ftag = fwe ? "R10" : ((rv && (ef || wf)) ? "R8" : "R9");
        @(negedge clk);
        check("R2", "cmd_q", {8'h00, cmd_q}, {8'h00, exp_cmd});
        check(atag, "action", {12'h000, erase_stb, write_stb, verify_stb, abort}, {12'h000, exp_act});
        check(ftag, "flags {perr,verr}", {14'h0, protect_err, verify_err}, {14'h0, exp_p, exp_v});
        check("R12", "onehot", {15'h0, ($countones({erase_stb, write_stb, verify_stb, abort}) > 1)}, 16'h0);
    endtask

    task automatic idle();
        step(1'b0, 8'h00, '0, '0, '0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b11);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1", "cmd_q after reset", {8'h00, cmd_q}, 16'h0000);
        check("R1", "outputs after reset",
              {10'h0, erase_stb, write_stb, verify_stb, abort, verify_err, protect_err}, 16'h0000);

        // R3: erase at the boundary itself is allowed
        step(1'b1, 8'h01, 4'd5, 4'd5, '0, '0, 0, 0, 0, 0, 2'b11);
        idle();
        // R3: boundary 0 protects nothing
        step(1'b1, 8'h01, 4'd0, 4'd0, '0, '0, 0, 0, 0, 0, 2'b11);
        // R4: erase just below the boundary is blocked
        step(1'b1, 8'h01, 4'd4, 4'd5, '0, '0, 0, 0, 0, 0, 2'b11);
        // R9: a clean write afterwards keeps the flags
        step(1'b1, 8'h02, 4'd9, 4'd2, 16'hFFFF, 16'h1234, 0, 0, 0, 0, 2'b11);
        // R10: writing 1s leaves flags, writing 0s clears
        step(1'b0, 8'h00, '0, '0, '0, '0, 0, 0, 0, 1, 2'b11);
        step(1'b0, 8'h00, '0, '0, '0, '0, 0, 0, 0, 1, 2'b00);
        // R5: dirty bit only in the upper byte
        step(1'b1, 8'h02, 4'd9, 4'd2, 16'h7FFF, 16'h8000, 0, 0, 0, 0, 2'b11);
        step(1'b0, 8'h00, '0, '0, '0, '0, 0, 0, 0, 1, 2'b00);
        // R6: writing the stored value is clean
        step(1'b1, 8'h02, 4'd15, 4'd15, 16'h5AA5, 16'h5AA5, 0, 0, 0, 0, 2'b11);
        // R7: verify inside protected region
        step(1'b1, 8'h03, 4'd0, 4'd15, '0, '0, 0, 0, 0, 0, 2'b11);
        // R11: unknown codes
        step(1'b1, 8'h00, 4'd0, 4'd15, '0, '0, 0, 0, 0, 0, 2'b11);
        step(1'b1, 8'hFF, 4'd0, 4'd15, '0, 16'hFFFF, 0, 0, 0, 0, 2'b11);
        // R8: verify failure sets only the verify flag
        step(1'b0, 8'h00, '0, '0, '0, '0, 1, 1, 0, 0, 2'b11);
        step(1'b0, 8'h00, '0, '0, '0, '0, 1, 0, 1, 0, 2'b11);
        // R8: failure bits without res_valid are ignored
        step(1'b0, 8'h00, '0, '0, '0, '0, 0, 0, 0, 1, 2'b00);
        step(1'b0, 8'h00, '0, '0, '0, '0, 0, 1, 1, 0, 2'b11);
        // R10: clear and set in the same cycle, set wins
        step(1'b1, 8'h02, 4'd1, 4'd3, '0, '0, 0, 0, 0, 1, 2'b00);
        idle();

        // Constrained random
        for (int i = 0; i < 2000; i++) begin
            logic [7:0] code;
            logic [3:0] sel;
            sel = 4'($urandom_range(0, 15));
            if (sel < 4)       code = 8'h01;
            else if (sel < 9)  code = 8'h02;
            else if (sel < 12) code = 8'h03;
            else               code = 8'($urandom);
            step(1'($urandom_range(0, 3) != 0), code,
                 AHW'($urandom), AHW'($urandom_range(0, 8)),
                 DW'($urandom) | DW'($urandom), DW'($urandom) & DW'($urandom) & DW'($urandom),
                 1'($urandom_range(0, 5) == 0), 1'($urandom), 1'($urandom),
                 1'($urandom_range(0, 4) == 0), 2'($urandom));
        end
        idle();

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule